// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block keeps the base address of a memory burst and presents the address of the current beat. When the parent block signals a new access, the whole address is registered. The two least significant bits then become the starting point of a four-beat burst. Each advance pulse moves the burst to its next beat. The upper address bits stay fixed until the next load.

The two low bits follow one of two orders, selected by a static mode input. Interleaved order combines the start value and the beat number with exclusive-or. Linear order adds the beat number to the start value, modulo four. After the fourth beat the sequence wraps to its start. Strobe decoding and chip-select qualification belong to the parent block, which hands this block only clean load and advance pulses.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `addr_o` is all zeros.
- R2: When `load_i` is high at a rising clock edge, `addr_o` equals the `addr_i` sampled at that edge from the following cycle onward. The burst beat returns to 0.
- R3: An advance never changes the bits of `addr_o` above the low two. Only a load changes them.
- R4: With `mode_i` = 1 (interleaved), the low two bits at beat k (k = 0..3) equal start XOR k. For example, start 2'b10 gives 10, 11, 00, 01.
- R5: With `mode_i` = 0 (linear), the low two bits at beat k equal (start + k) mod 4. For example, start 2'b01 gives 01, 10, 11, 00.
- R6: An advance taken at the fourth beat returns the low two bits to the start value.
- R7: A load during a burst replaces the base address and restarts at beat 0. When `load_i` and `adv_i` are both high in the same cycle, the load wins.
- R8: With `load_i` and `adv_i` both low and `mode_i` steady, `addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Register `addr_i` and start a new burst |
| addr_i | input | ADDR_W | Address to register on a load |
| adv_i | input | 1 | Move to the next beat of the burst |
| mode_i | input | 1 | Burst order: 1 = interleaved (the default tie-off), 0 = linear |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The bench builds the block with its default parameters: an 18-bit address, of which 2 bits are the beat counter. This lets it compare an address with a non-trivial upper field bit for bit across whole bursts. It also exercises the exact four-beat wrap in both orders. Start values 01 and 10 are used because the two orders diverge from 01 and agree from 10. Toggling the mode in the middle of a burst shows that the order is applied to a stored beat number, not to a stored address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int DEF_ADDR_W = 18;
    localparam int DEF_CNT_W  = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } seq_cmd_e;

    // Load takes priority over advance.
    function automatic seq_cmd_e decode_cmd(input logic load, input logic adv);
        if (load)
            return CMD_LOAD;
        else if (adv)
            return CMD_STEP;
        else
            return CMD_HOLD;
    endfunction

    function automatic order_e order_from_pin(input logic mode);
        return mode ? ORD_INTERLEAVE : ORD_LINEAR;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int UPPER_W = ADDR_W - CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  seq_cmd_e           cmd,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [UPPER_W-1:0] upper_o,
    output logic [CNT_W-1:0]   start_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_o <= '0;
            start_o <= '0;
        end else if (cmd == CMD_LOAD) begin
            upper_o <= addr_i[ADDR_W-1:CNT_W];
            start_o <= addr_i[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cmd_e         cmd,
    output logic [CNT_W-1:0] beat_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Natural wraparound of the counter gives the return to the start beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: beat_o <= '0;
                CMD_STEP: beat_o <= beat_o + ONE;
                default:  beat_o <= beat_o;
            endcase
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [CNT_W-1:0] low_o
);

    logic [CNT_W-1:0] xor_val;
    logic [CNT_W-1:0] sum_val;

    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_val[b] = start_i[b] ^ beat_i[b];
    end

    assign sum_val = start_i + beat_i;

    always_comb begin
        case (order_i)
            ORD_INTERLEAVE: low_o = xor_val;
            default:        low_o = sum_val;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UPPER_W = ADDR_W - CNT_W;

    seq_cmd_e           cmd;
    order_e             order;
    logic [UPPER_W-1:0] upper;
    logic [CNT_W-1:0]   start;
    logic [CNT_W-1:0]   beat;
    logic [CNT_W-1:0]   low;

    assign cmd   = decode_cmd(load_i, adv_i);
    assign order = order_from_pin(mode_i);

    burst_base_reg #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) base_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_i  (addr_i),
        .upper_o (upper),
        .start_o (start)
    );

    burst_beat_ctr #(
        .CNT_W (CNT_W)
    ) ctr_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .beat_o (beat)
    );

    burst_order_map #(
        .CNT_W (CNT_W)
    ) map_i (
        .start_i (start),
        .beat_i  (beat),
        .order_i (order),
        .low_o   (low)
    );

    assign addr_o = {upper, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              adv_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] addr_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(addr_i))) else $error("load capture"); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W])))
        else $error("upper bits moved"); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && !mode_i) |=>
            (mode_i || addr_o[CNT_W-1:0] == $past(addr_o[CNT_W-1:0]) + ONE))
        else $error("linear step"); // R5

    AST_INTERLEAVE_MOVES: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && mode_i) |=>
            (!mode_i || addr_o[CNT_W-1:0] != $past(addr_o[CNT_W-1:0])))
        else $error("interleave step"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_i) |=>
            ((mode_i != $past(mode_i)) || (addr_o == $past(addr_o))))
        else $error("idle hold"); // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .addr_i (addr_i),
    .adv_i  (adv_i),
    .mode_i (mode_i),
    .addr_o (addr_o)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_i;
    logic [AW-1:0] addr_i;
    logic          adv_i;
    logic          mode_i;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .addr_i (addr_i),
        .adv_i  (adv_i),
        .mode_i (mode_i),
        .addr_o (addr_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the inputs cover one rising edge.
    task automatic step(input logic ld, input logic [AW-1:0] a, input logic av);
        load_i = ld;
        addr_i = a;
        adv_i  = av;
        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; load_i = 0; adv_i = 0; addr_i = '0; mode_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", addr_o, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", addr_o, '0);
    endtask

    task automatic t_interleave();
        logic [1:0] seq [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
        logic [AW-1:0] base = 18'h2A5B6;
        mode_i = 1'b1;
        step(1'b1, base, 1'b0);
        chk("R2 load interleaved", addr_o, base);
        for (int k = 1; k < 4; k++) begin
            step(1'b0, '0, 1'b1);
            chk("R4 interleaved beat", addr_o, {base[AW-1:2], seq[k]});
        end
        step(1'b0, '0, 1'b1);
        chk("R6 interleaved wrap", addr_o, base);
    endtask

    task automatic t_linear(input logic [AW-1:0] base);
        mode_i = 1'b0;
        step(1'b1, base, 1'b0);
        chk("R2 load linear", addr_o, base);
        for (int k = 1; k < 4; k++) begin
            step(1'b0, '0, 1'b1);
            chk("R5 linear beat", addr_o, {base[AW-1:2], 2'(base[1:0] + k[1:0])});
        end
        step(1'b0, '0, 1'b1);
        chk("R6 linear wrap", addr_o, base);
        chk("R3 upper fixed", {16'(addr_o[AW-1:2]), 2'b00}, {16'(base[AW-1:2]), 2'b00});
    endtask

    task automatic t_hold();
        logic [AW-1:0] seen;
        mode_i = 1'b1;
        step(1'b1, 18'h1F0F1, 1'b0);
        step(1'b0, '0, 1'b1);
        seen = addr_o;
        chk("R4 beat1 from 01", seen, 18'h1F0F0);
        repeat (3) step(1'b0, 18'h3FFFF, 1'b0);
        chk("R8 idle hold", addr_o, seen);
        // Same stored beat, other order: (01 + 1) mod 4 = 10.
        mode_i = 1'b0;
        #1;
        chk("R5 mode picks linear", addr_o, 18'h1F0F2);
        mode_i = 1'b1;
        #1;
        chk("R4 mode picks interleave", addr_o, 18'h1F0F0);
    endtask

    task automatic t_reload();
        mode_i = 1'b0;
        step(1'b1, 18'h00004, 1'b0);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        chk("R5 before reload", addr_o, 18'h00006);
        step(1'b1, 18'h3C003, 1'b0);
        chk("R7 reload mid burst", addr_o, 18'h3C003);
        step(1'b0, '0, 1'b1);
        chk("R7 restart beat", addr_o, 18'h3C000);
        step(1'b1, 18'h12345, 1'b1);
        chk("R7 load beats advance", addr_o, 18'h12345);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_interleave();
        t_linear(18'h0ABC9);
        t_linear(18'h35556);
        t_hold();
        t_reload();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule